// File: doc/BRIEF.md
# Lane Elastic Buffer with Latency Report

This block carries a stream of 66-bit line words from a recovered lane clock into a faster local clock. Each word holds 64 payload bits and a 2-bit sync header. The write side stores one word on every write-clock edge. The read side stays silent until the buffer has collected a programmable number of words. From then on it delivers one word on every read-clock edge.

An overflow or underflow raises a one-cycle error pulse. The buffer then drops into a fixed recovery period, and on leaving it the buffer must fill to the threshold again before output resumes. An external hold input forces the same recovery state, for use while the clocks are still settling.

The buffer reports its latency as the occupancy, in read-clock words, seen at each read. It passes that number to a consumer in another clock domain through a ready/acknowledge handshake. If the acknowledge is tied high, the reported value simply follows the live occupancy.

Top module: `lane_elastic_fifo`

## Requirements
- R1: Every word read out equals a word written in, payload and header together, in write order with no word lost or repeated while `rd_valid` stays high.
- R2: After recovery, `rd_valid` stays low until the read-side occupancy reaches `fill_level`. A `fill_level` of 0 acts as 1.
- R3: While running with no error, `rd_valid` is high on every read-clock cycle, delivering one word per cycle.
- R4: If the occupancy is zero while running, the block raises `fifo_err` for exactly one read cycle, and `rd_valid` is low from the next cycle.
- R5: If the read-side occupancy reaches DEPTH-8 (504 words at the default depth of 512), the block raises a one-cycle `fifo_err` and enters recovery.
- R6: After an error or a hold, the block stays in recovery for RECOV_CYC (16) read cycles. It then refills to the threshold, so the first valid word appears no sooner than `fill_level`+16 read cycles later.
- R7: While `hold_rst` is high, `rd_valid`, `fifo_err` and `lat_rdy` are all low.
- R8: `lat_value` is the occupancy, in words, seen at a read, zero-extended to 16 bits. With equal write and read clock rates it lies between `fill_level`-1 and `fill_level`+3.
- R9: `lat_rdy` rises after reading starts and is low from the cycle after the block stops running, whether by error or by hold.
- R10: A rising edge on `lat_ack` drops `lat_rdy` for one cycle, after which a fresh value is presented with `lat_rdy` high.
- R11: While `lat_ack` stays low, `lat_value` does not change, even when the occupancy changes.
- R12: While `lat_ack` is held high, `lat_value` is reloaded every cycle and follows the occupancy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered lane clock (write side) |
| wr_data | input | 64 | Payload bits of the incoming word |
| wr_head | input | 2 | Sync header of the incoming word |
| rd_clk | input | 1 | Fast local clock (read side) |
| hold_rst | input | 1 | Synchronous active-high hold, read domain |
| fill_level | input | 9 | Words to buffer before reading starts |
| rd_data | output | 64 | Payload bits of the outgoing word |
| rd_head | output | 2 | Sync header of the outgoing word |
| rd_valid | output | 1 | Outgoing word is valid this cycle |
| fifo_err | output | 1 | One-cycle pulse on overflow or underflow |
| lat_ack | input | 1 | Consumer acknowledge, asynchronous level |
| lat_value | output | 16 | Reported occupancy in read-clock words |
| lat_rdy | output | 1 | `lat_value` is ready to be taken |

## Verification
The assertions assume that `fill_level` stays constant while the block is running. They also assume that each `lat_ack` pulse lasts at least one read cycle, and that the write clock runs during recovery at no less than half the read rate, so the synchronizers are flushed before refilling starts. The stimulus changes `fill_level` only under `hold_rst` and holds each acknowledge pulse for two read cycles. It varies the write half-period only between 2 ns and 4 ns, and it stops the write clock only to force an underflow, restarting it as soon as the error pulse is seen.

// File: rtl/efifo_pkg.sv
package efifo_pkg;

    localparam int DATA_W  = 64;
    localparam int HEAD_W  = 2;
    localparam int GRAY_MX = 16;

    typedef struct packed {
        logic [HEAD_W-1:0] head;
        logic [DATA_W-1:0] data;
    } lane_word_t;

    typedef enum logic [1:0] {
        RD_RECOVER = 2'd0,
        RD_FILL    = 2'd1,
        RD_RUN     = 2'd2
    } rd_state_e;

    function automatic logic [GRAY_MX-1:0] to_gray(input logic [GRAY_MX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_MX-1:0] from_gray(input logic [GRAY_MX-1:0] g);
        logic [GRAY_MX-1:0] b;
        b[GRAY_MX-1] = g[GRAY_MX-1];
        for (int i = GRAY_MX-2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/efifo_gsync.sv
module efifo_gsync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/efifo_wr_ctrl.sv
module efifo_wr_ctrl
    import efifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] rgray_s,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [PW-1:0] wgray
);
    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wocc;
    logic [PW-1:0] wnext;

    assign rbin_s  = PW'(from_gray(GRAY_MX'(rgray_s)));
    assign wocc    = wbin - rbin_s;
    assign wr_en   = !rst && (wocc < PW'(DEPTH));
    assign wr_addr = wbin[AW-1:0];
    assign wnext   = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wbin  <= wnext;
            wgray <= PW'(to_gray(GRAY_MX'(wnext)));
        end
    end
endmodule

// File: rtl/efifo_rd_ctrl.sv
module efifo_rd_ctrl
    import efifo_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int FILL_W    = 9,
    parameter int RECOV_CYC = 16,
    parameter int SLACK     = 8,
    parameter int AW        = $clog2(DEPTH),
    parameter int PW        = AW + 1
) (
    input  logic              clk,
    input  logic              hold_rst,
    input  logic [FILL_W-1:0] fill_level,
    input  logic [PW-1:0]     wgray_s,
    output logic              rd_fire,
    output logic [AW-1:0]     rd_addr,
    output logic [PW-1:0]     rgray,
    output logic              in_reset,
    output logic              running,
    output logic              fifo_err,
    output logic [PW-1:0]     occ,
    output logic [PW-1:0]     thr_eff
);
    localparam int CW = $clog2(RECOV_CYC + 1);
    localparam logic [PW-1:0] FULL_MARK = PW'(DEPTH - SLACK);

    rd_state_e     state;
    logic [CW-1:0] cnt;
    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin_s;
    logic          over;
    logic          under;

    assign wbin_s   = PW'(from_gray(GRAY_MX'(wgray_s)));
    assign occ      = wbin_s - rbin;
    assign thr_eff  = (fill_level == '0) ? PW'(1) : PW'(fill_level);
    assign over     = (occ >= FULL_MARK);
    assign under    = (occ == '0);
    assign in_reset = (state == RD_RECOVER);
    assign running  = (state == RD_RUN);
    assign rd_fire  = running && !over && !under;
    assign rd_addr  = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        fifo_err <= 1'b0;
        if (hold_rst) begin
            state <= RD_RECOVER;
            cnt   <= CW'(RECOV_CYC - 1);
            rbin  <= '0;
            rgray <= '0;
        end else begin
            unique case (state)
                RD_RECOVER: begin
                    rbin  <= '0;
                    rgray <= '0;
                    if (cnt == '0) state <= RD_FILL;
                    else           cnt   <= cnt - CW'(1);
                end
                RD_FILL: begin
                    if (over) begin
                        fifo_err <= 1'b1;
                        state    <= RD_RECOVER;
                        cnt      <= CW'(RECOV_CYC - 1);
                    end else if (occ >= thr_eff) begin
                        state <= RD_RUN;
                    end
                end
                RD_RUN: begin
                    if (over || under) begin
                        fifo_err <= 1'b1;
                        state    <= RD_RECOVER;
                        cnt      <= CW'(RECOV_CYC - 1);
                    end else begin
                        rbin  <= rbin + PW'(1);
                        rgray <= PW'(to_gray(GRAY_MX'(rbin + PW'(1))));
                    end
                end
                default: begin
                    state <= RD_RECOVER;
                    cnt   <= CW'(RECOV_CYC - 1);
                end
            endcase
        end
    end
endmodule

// File: rtl/efifo_lat_port.sv
module efifo_lat_port #(
    parameter int PW    = 10,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic [PW-1:0]    occ,
    input  logic             ack_s,
    output logic [LAT_W-1:0] lat_value,
    output logic             lat_rdy
);
    logic ack_d;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            lat_rdy <= 1'b0;
            ack_d   <= 1'b0;
        end else begin
            ack_d <= ack_s;
            if (!lat_rdy) begin
                lat_value <= LAT_W'(occ);
                lat_rdy   <= 1'b1;
            end else if (ack_s && !ack_d) begin
                lat_rdy <= 1'b0;
            end else if (ack_s) begin
                lat_value <= LAT_W'(occ);
            end
        end
    end
endmodule

// File: rtl/lane_elastic_fifo.sv
module lane_elastic_fifo
    import efifo_pkg::*;
#(
    parameter int DEPTH       = 512,
    parameter int FILL_W      = 9,
    parameter int LAT_W       = 16,
    parameter int RECOV_CYC   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [HEAD_W-1:0] wr_head,
    input  logic              rd_clk,
    input  logic              hold_rst,
    input  logic [FILL_W-1:0] fill_level,
    output logic [DATA_W-1:0] rd_data,
    output logic [HEAD_W-1:0] rd_head,
    output logic              rd_valid,
    output logic              fifo_err,
    input  logic              lat_ack,
    output logic [LAT_W-1:0]  lat_value,
    output logic              lat_rdy
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 1;
    localparam int SLACK = 8;

    lane_word_t    mem [DEPTH];
    lane_word_t    in_word;
    lane_word_t    out_q;
    logic          wr_rst;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray_s;
    logic          rd_fire;
    logic [AW-1:0] rd_addr;
    logic          in_reset;
    logic          running;
    logic [PW-1:0] occ;
    logic [PW-1:0] thr_eff;
    logic          ack_s;

    assign in_word.data = wr_data;
    assign in_word.head = wr_head;

    efifo_gsync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(wr_clk), .rst(1'b0), .d(in_reset), .q(wr_rst)
    );

    efifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
    );

    efifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk(rd_clk), .rst(in_reset), .d(wgray), .q(wgray_s)
    );

    efifo_gsync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(rd_clk), .rst(in_reset), .d(lat_ack), .q(ack_s)
    );

    efifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .rgray_s(rgray_s),
        .wr_en(wr_en), .wr_addr(wr_addr), .wgray(wgray)
    );

    efifo_rd_ctrl #(
        .DEPTH(DEPTH), .FILL_W(FILL_W), .RECOV_CYC(RECOV_CYC), .SLACK(SLACK)
    ) u_rd (
        .clk(rd_clk), .hold_rst(hold_rst), .fill_level(fill_level),
        .wgray_s(wgray_s), .rd_fire(rd_fire), .rd_addr(rd_addr),
        .rgray(rgray), .in_reset(in_reset), .running(running),
        .fifo_err(fifo_err), .occ(occ), .thr_eff(thr_eff)
    );

    efifo_lat_port #(.PW(PW), .LAT_W(LAT_W)) u_lat (
        .clk(rd_clk), .rst(in_reset), .running(running), .occ(occ),
        .ack_s(ack_s), .lat_value(lat_value), .lat_rdy(lat_rdy)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= in_word;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_fire) out_q <= mem[rd_addr];
    end

    always_ff @(posedge rd_clk) begin
        if (in_reset) rd_valid <= 1'b0;
        else          rd_valid <= rd_fire;
    end

    assign rd_data = out_q.data;
    assign rd_head = out_q.head;
endmodule

// File: rtl/lane_elastic_fifo_chk.sv
module lane_elastic_fifo_chk #(
    parameter int PW    = 10,
    parameter int LAT_W = 16
) (
    input logic             rd_clk,
    input logic             wr_clk,
    input logic             hold_rst,
    input logic             wr_rst,
    input logic             in_reset,
    input logic [PW-1:0]    wgray,
    input logic [PW-1:0]    rgray,
    input logic             running,
    input logic [PW-1:0]    occ,
    input logic [PW-1:0]    thr_eff,
    input logic             fifo_err,
    input logic             rd_valid,
    input logic             lat_rdy,
    input logic [LAT_W-1:0] lat_value,
    input logic             ack_s
);
    // R1
    wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R1
    rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (hold_rst || in_reset)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R2
    fill_gate_chk: assert property (@(posedge rd_clk) disable iff (hold_rst)
        (running && !$past(running)) |-> ($past(occ) >= $past(thr_eff)));

    // R3
    valid_needs_run_chk: assert property (@(posedge rd_clk) disable iff (hold_rst)
        rd_valid |-> $past(running));

    // R4
    err_single_chk: assert property (@(posedge rd_clk) disable iff (hold_rst)
        fifo_err |=> !fifo_err);

    // R4
    err_stops_out_chk: assert property (@(posedge rd_clk) disable iff (hold_rst)
        fifo_err |=> (!rd_valid && !lat_rdy));

    // R9
    rdy_needs_run_chk: assert property (@(posedge rd_clk) disable iff (hold_rst)
        !running |=> !lat_rdy);

    // R11
    lat_hold_chk: assert property (@(posedge rd_clk) disable iff (hold_rst)
        (lat_rdy && $past(lat_rdy) && !$past(ack_s)) |-> $stable(lat_value));
endmodule

bind lane_elastic_fifo lane_elastic_fifo_chk #(.PW(PW), .LAT_W(LAT_W)) u_chk (
    .rd_clk(rd_clk), .wr_clk(wr_clk), .hold_rst(hold_rst), .wr_rst(wr_rst),
    .in_reset(in_reset), .wgray(wgray), .rgray(rgray), .running(running),
    .occ(occ), .thr_eff(thr_eff), .fifo_err(fifo_err), .rd_valid(rd_valid),
    .lat_rdy(lat_rdy), .lat_value(lat_value), .ack_s(ack_s)
);

// File: tb/lane_elastic_fifo_bench.sv
`timescale 1ns/1ps
module lane_elastic_fifo_bench;
    localparam int RECOV = 16;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic [63:0] wr_data;
    logic [1:0]  wr_head;
    logic        hold_rst = 1'b1;
    logic [8:0]  fill_level = 9'd64;
    logic [63:0] rd_data;
    logic [1:0]  rd_head;
    logic        rd_valid;
    logic        fifo_err;
    logic        lat_ack = 1'b0;
    logic [15:0] lat_value;
    logic        lat_rdy;

    realtime     wr_half = 4.0;
    bit          wr_run  = 1'b1;
    logic [63:0] wseq    = 64'h0123_4567_0000_0000;

    int n_chk  = 0;
    int n_fail = 0;
    int seq_err = 0;
    int valid_cnt = 0;
    int err_cnt = 0;
    bit have_prev = 1'b0;
    logic [63:0] prev;

    lane_elastic_fifo u_lane_elastic_fifo (
        .wr_clk(wr_clk), .wr_data(wr_data), .wr_head(wr_head),
        .rd_clk(rd_clk), .hold_rst(hold_rst), .fill_level(fill_level),
        .rd_data(rd_data), .rd_head(rd_head), .rd_valid(rd_valid),
        .fifo_err(fifo_err), .lat_ack(lat_ack), .lat_value(lat_value),
        .lat_rdy(lat_rdy)
    );

    initial forever #4 rd_clk = ~rd_clk;

    initial begin
        #1.3;
        forever begin
            #(wr_half);
            if (wr_run) wr_clk = ~wr_clk;
        end
    end

    always @(negedge wr_clk) wseq <= wseq + 64'd1;
    assign wr_data = wseq;
    assign wr_head = wseq[0] ? 2'b10 : 2'b01;

    always @(negedge rd_clk) begin
        if (fifo_err) err_cnt++;
        if (rd_valid) begin
            valid_cnt++;
            if (rd_head != (rd_data[0] ? 2'b10 : 2'b01)) seq_err++;
            if (have_prev && rd_data != prev + 64'd1) seq_err++;
            prev = rd_data;
            have_prev = 1'b1;
        end else begin
            have_prev = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rd(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic t_reset();
        @(negedge rd_clk);
        hold_rst = 1'b1;
        wait_rd(3);
        check(rd_valid == 1'b0, "R7", "rd_valid under hold", rd_valid, 0);
        check(fifo_err == 1'b0, "R7", "fifo_err under hold", fifo_err, 0);
        check(lat_rdy == 1'b0, "R7", "lat_rdy under hold", lat_rdy, 0);
    endtask

    task automatic t_fill(input int thr);
        int n;
        int eff;
        eff = (thr == 0) ? 1 : thr;
        t_reset();
        fill_level = 9'(thr);
        wait_rd(2);
        hold_rst = 1'b0;
        n = 0;
        while (!rd_valid && n < 3000) begin
            @(negedge rd_clk);
            n++;
        end
        check(n >= eff + RECOV && n <= eff + RECOV + 20, "R2",
              "cycles from hold release to first word", n, eff + RECOV + 8);
    endtask

    task automatic t_stream();
        @(posedge rd_clk);
        seq_err = 0;
        valid_cnt = 0;
        err_cnt = 0;
        wait_rd(300);
        @(posedge rd_clk);
        check(seq_err == 0, "R1", "word order and content errors", seq_err, 0);
        check(valid_cnt == 300, "R3", "valid cycles out of 300", valid_cnt, 300);
        check(err_cnt == 0, "R3", "error pulses during steady stream", err_cnt, 0);
    endtask

    task automatic t_latency(input int thr);
        @(negedge rd_clk);
        check(lat_rdy == 1'b1, "R9", "lat_rdy while running", lat_rdy, 1);
        check(int'(lat_value) >= thr - 1 && int'(lat_value) <= thr + 3, "R8",
              "latency in words", lat_value, thr);
    endtask

    task automatic t_handshake();
        bit saw_low;
        logic [15:0] v0;
        saw_low = 1'b0;
        @(negedge rd_clk);
        lat_ack = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge rd_clk);
            if (i == 1) lat_ack = 1'b0;
            if (!lat_rdy) saw_low = 1'b1;
        end
        check(saw_low, "R10", "lat_rdy dropped after ack edge", saw_low, 1);
        check(lat_rdy == 1'b1, "R10", "lat_rdy back after ack edge", lat_rdy, 1);

        v0 = lat_value;
        wr_half = 3.5;
        wait_rd(60);
        check(lat_value == v0, "R11", "value held while ack low", lat_value, v0);

        lat_ack = 1'b1;
        wait_rd(60);
        check(lat_value > v0, "R12", "value follows occupancy with ack high",
              lat_value, v0 + 1);
        check(lat_rdy == 1'b1, "R12", "lat_rdy with ack held", lat_rdy, 1);
        lat_ack = 1'b0;
        wr_half = 4.0;
        wait_rd(20);
    endtask

    task automatic t_underflow(input int thr);
        int n;
        bit seen;
        seen = 1'b0;
        @(negedge rd_clk);
        wr_run = 1'b0;
        n = 0;
        while (!seen && n < 1000) begin
            @(negedge rd_clk);
            n++;
            if (fifo_err) seen = 1'b1;
        end
        wr_run = 1'b1;
        check(seen, "R4", "error on underflow", seen, 1);
        @(negedge rd_clk);
        check(fifo_err == 1'b0, "R4", "error lasts one cycle", fifo_err, 0);
        check(rd_valid == 1'b0, "R4", "no word after underflow", rd_valid, 0);
        check(lat_rdy == 1'b0, "R9", "lat_rdy low after error", lat_rdy, 0);
        n = 1;
        while (!rd_valid && n < 3000) begin
            @(negedge rd_clk);
            n++;
        end
        check(n >= thr + RECOV && n <= thr + RECOV + 24, "R6",
              "cycles from underflow to first word", n, thr + RECOV + 8);
    endtask

    task automatic t_overflow(input int thr);
        int n;
        bit seen;
        seen = 1'b0;
        @(negedge rd_clk);
        wr_half = 2.0;
        n = 0;
        while (!seen && n < 4000) begin
            @(negedge rd_clk);
            n++;
            if (fifo_err) seen = 1'b1;
        end
        wr_half = 4.0;
        check(seen, "R5", "error on overflow", seen, 1);
        check(n > 400, "R5", "overflow not before buffer nearly full", n, 900);
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R5", "no word after overflow", rd_valid, 0);
        n = 1;
        while (!rd_valid && n < 3000) begin
            @(negedge rd_clk);
            n++;
        end
        check(n >= thr + RECOV && n <= thr + RECOV + 28, "R6",
              "cycles from overflow to first word", n, thr + RECOV + 8);
    endtask

    initial begin
        #(8.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_rd(20);
        t_reset();
        t_fill(64);
        t_stream();
        t_latency(64);
        t_handshake();
        t_underflow(64);
        t_stream();
        t_overflow(64);
        t_stream();
        t_fill(20);
        t_stream();
        t_latency(20);
        t_fill(0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule